// File: doc/BRIEF.md
# Phase-Frequency Detector with Backlash Pulse

This block compares two pulse streams: one from a reference divider and one from a feedback divider. From the comparison it produces the UP and DOWN controls for a charge pump. Both streams are sampled on a fast clock. A new rising edge on the reference sets UP, and a new rising edge on the divider input sets DOWN. When both controls are high, the block clears them together. It does this only after they have overlapped for a programmed number of clock cycles, called the backlash window.

Because of this forced overlap, both pump switches are on in every comparison cycle, even when the inputs are perfectly aligned. This removes the dead zone of the pump around zero phase error. When the two inputs differ in frequency, the leading control stays high across several reference periods, so the block also detects frequency error.

A two-bit pump current code passes through a register to a separate output.

Top module: `pfd_backlash`

## Requirements
- R1: While `rst` is high at a clock edge, `pump_up`, `pump_dn` and `cp_code` are all 0 after that edge.
- R2: A 0-to-1 change of `ref_pulse` between two clock edges sets `pump_up` at the second edge. A level that stays high does not set it again after it has been cleared.
- R3: A 0-to-1 change of `div_pulse` between two clock edges sets `pump_dn` at the second edge. If the divider leads by d cycles, `pump_dn` stays high for d+L cycles and `pump_up` stays high for L cycles.
- R4: If both inputs rise at the same edge, `pump_up` and `pump_dn` are both high for exactly L clock cycles and then fall at the same edge. L is the effective backlash length.
- R5: If the reference leads by d cycles, `pump_up` stays high for d+L cycles and `pump_dn` stays high for L cycles. Both fall at the same edge. A control never falls unless the other one was also high.
- R6: Extra reference edges that arrive while `pump_up` is high and `pump_dn` is low keep `pump_up` high and leave `pump_dn` low. The next divider edge then gives one overlap of L cycles.
- R7: The effective length L equals `blk_len` for values 1 to 15. A value of 0 is treated as 1. `blk_len` is held stable outside reset.
- R8: `cp_code` equals the value of `cp_sel` at the previous clock edge. The two bits are passed through unchanged.
- R9: If an input edge lands on the same edge that clears the overlap, the set wins. That control is high after the edge and the other one is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Reference divider pulse stream |
| div_pulse | input | 1 | Feedback divider pulse stream |
| blk_len | input | 4 | Backlash overlap length in clock cycles (0 acts as 1) |
| cp_sel | input | 2 | Pump current selection |
| pump_up | output | 1 | Charge pump UP control |
| pump_dn | output | 1 | Charge pump DOWN control |
| cp_code | output | 2 | Registered pump current selection |

## Verification
An input changed between edges k-1 and k sets its control at edge k. The first overlap cycle is therefore visible just after edge k. The shared clear lands at edge k+L, counted from the edge where the second control was set. `cp_code` follows `cp_sel` one edge later.

The bench drives every input on the falling clock edge and samples on the next falling edge. For each pulse it walks forward one cycle at a time and compares both controls with the expected level for that cycle. This checks the exact widths d+L and L, the simultaneous fall, and the collision case.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned BLK_W = 4;
  localparam int unsigned CP_W  = 2;
  localparam int unsigned N_CH  = 2;
  localparam int unsigned CH_UP = 0;
  localparam int unsigned CH_DN = 1;
endpackage

// File: rtl/pfd_flag.sv
module pfd_flag (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  input  logic clr,
  output logic flag
);
  logic pulse_d;
  logic rise;

  assign rise = pulse_in & ~pulse_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_d <= 1'b0;
      flag    <= 1'b0;
    end else begin
      pulse_d <= pulse_in;
      if (rise)
        flag <= 1'b1;
      else if (clr)
        flag <= 1'b0;
    end
  end

  // R9: a fresh edge always leaves the control high, even on a clear edge
  p_edge_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && !pulse_d) |=> flag);
endmodule

// File: rtl/pfd_bl_timer.sv
module pfd_bl_timer #(
  parameter int unsigned BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up,
  input  logic             dn,
  input  logic [BLK_W-1:0] blk_len,
  output logic             clr
);
  localparam logic [BLK_W-1:0] ONE = BLK_W'(1);

  logic [BLK_W-1:0] cnt;
  logic [BLK_W-1:0] eff;
  logic             both;

  assign eff  = (blk_len == '0) ? ONE : blk_len;
  assign both = up & dn;
  assign clr  = both && (cnt == eff - ONE);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (clr || !both)
      cnt <= '0;
    else
      cnt <= cnt + ONE;
  end

  // R4: overlap ends only once the window has been counted out
  p_overlap_len_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(up && dn) |-> ($past(cnt) == $past(eff) - ONE));

  // R7: count stays inside the effective window
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt < eff);
endmodule

// File: rtl/pfd_backlash.sv
module pfd_backlash
  import pfd_pkg::*;
#(
  parameter int unsigned BL_W = BLK_W,
  parameter int unsigned C_W  = CP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_pulse,
  input  logic            div_pulse,
  input  logic [BL_W-1:0] blk_len,
  input  logic [C_W-1:0]  cp_sel,
  output logic            pump_up,
  output logic            pump_dn,
  output logic [C_W-1:0]  cp_code
);
  logic [N_CH-1:0] pulses;
  logic [N_CH-1:0] flags;
  logic            clr;

  assign pulses[CH_UP] = ref_pulse;
  assign pulses[CH_DN] = div_pulse;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pfd_flag u_flag (
      .clk      (clk),
      .rst      (rst),
      .pulse_in (pulses[g]),
      .clr      (clr),
      .flag     (flags[g])
    );
  end

  pfd_bl_timer #(.BLK_W(BL_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .up      (flags[CH_UP]),
    .dn      (flags[CH_DN]),
    .blk_len (blk_len),
    .clr     (clr)
  );

  assign pump_up = flags[CH_UP];
  assign pump_dn = flags[CH_DN];

  always_ff @(posedge clk) begin
    if (rst)
      cp_code <= '0;
    else
      cp_code <= cp_sel;
  end

  // R1: reset clears every output
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!pump_up && !pump_dn && cp_code == '0));

  // R6: UP alone never drops
  p_up_alone_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (pump_up && !pump_dn) |=> pump_up);

  // R3: DOWN alone never drops
  p_dn_alone_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (pump_dn && !pump_up) |=> pump_dn);

  // R5: a control only falls out of an overlap
  p_fall_from_pair_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(pump_dn) || $fell(pump_up)) |-> ($past(pump_up) && $past(pump_dn)));

  // R8: current code follows its input one edge later
  p_cp_pass_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cp_code == $past(cp_sel)));
endmodule

// File: tb/pfd_backlash_bench.sv
module pfd_backlash_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_p = 1'b0;
  logic       div_p = 1'b0;
  logic [3:0] blk = 4'd3;
  logic [1:0] cp  = 2'd0;
  logic       up, dn;
  logic [1:0] cp_code;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pfd_backlash u_pfd_backlash (
    .clk(clk), .rst(rst), .ref_pulse(ref_p), .div_pulse(div_p),
    .blk_len(blk), .cp_sel(cp), .pump_up(up), .pump_dn(dn), .cp_code(cp_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // pair encodes {up,dn}
  task automatic chk_pair(input string req, input bit eu, input bit ed);
    chk({up, dn} == {eu, ed}, req, int'({up, dn}), int'({eu, ed}));
  endtask

  task automatic do_reset(input logic [3:0] len);
    rst = 1'b1; ref_p = 1'b0; div_p = 1'b0; blk = len;
    tick(2);
    chk(up == 1'b0 && dn == 1'b0 && cp_code == 2'd0, "R1 reset outputs",
        int'({up, dn, cp_code}), 0);
    rst = 1'b0;
  endtask

  task automatic t_aligned(input logic [3:0] len);
    int l = (len == 0) ? 1 : int'(len);
    do_reset(len);
    ref_p = 1'b1; div_p = 1'b1;
    tick();
    ref_p = 1'b0; div_p = 1'b0;
    for (int i = 0; i < l; i++) begin
      chk_pair((len == 0) ? "R7 zero length overlap" : "R4 aligned overlap", 1'b1, 1'b1);
      tick();
    end
    chk_pair("R4 aligned joint fall", 1'b0, 1'b0);
  endtask

  task automatic t_lead(input int d, input logic [3:0] len, input bit ref_first);
    string tag = ref_first ? "R5 reference lead" : "R3 divider lead";
    do_reset(len);
    if (ref_first) ref_p = 1'b1; else div_p = 1'b1;
    tick();
    ref_p = 1'b0; div_p = 1'b0;
    for (int i = 0; i < d; i++) begin
      chk_pair(tag, ref_first, !ref_first);
      if (i == d - 1) begin
        if (ref_first) div_p = 1'b1; else ref_p = 1'b1;
      end
      tick();
    end
    ref_p = 1'b0; div_p = 1'b0;
    for (int i = 0; i < int'(len); i++) begin
      chk_pair(tag, 1'b1, 1'b1);
      tick();
    end
    chk_pair(tag, 1'b0, 1'b0);
  endtask

  task automatic t_freq();
    do_reset(4'd2);
    ref_p = 1'b1; tick(); ref_p = 1'b0;
    chk_pair("R6 leading up", 1'b1, 1'b0);
    tick(2);
    ref_p = 1'b1; tick(); ref_p = 1'b0;
    chk_pair("R6 extra reference edge", 1'b1, 1'b0);
    tick(3);
    chk_pair("R6 up held across cycles", 1'b1, 1'b0);
    div_p = 1'b1; tick(); div_p = 1'b0;
    chk_pair("R6 overlap cycle 1", 1'b1, 1'b1);
    tick();
    chk_pair("R6 overlap cycle 2", 1'b1, 1'b1);
    tick();
    chk_pair("R6 single clear", 1'b0, 1'b0);
  endtask

  task automatic t_level();
    do_reset(4'd1);
    ref_p = 1'b1; tick();
    chk_pair("R2 reference edge sets up", 1'b1, 1'b0);
    div_p = 1'b1; tick(); div_p = 1'b0;
    chk_pair("R2 overlap", 1'b1, 1'b1);
    tick();
    chk_pair("R2 cleared", 1'b0, 1'b0);
    tick(3);
    chk_pair("R2 held level no retrigger", 1'b0, 1'b0);
    ref_p = 1'b0;
  endtask

  task automatic t_collide();
    do_reset(4'd2);
    ref_p = 1'b1; div_p = 1'b1; tick();
    ref_p = 1'b0; div_p = 1'b0;
    chk_pair("R9 overlap 1", 1'b1, 1'b1);
    tick();
    chk_pair("R9 overlap 2", 1'b1, 1'b1);
    ref_p = 1'b1; tick();
    chk_pair("R9 set wins over clear", 1'b1, 1'b0);
    ref_p = 1'b0; tick();
    chk_pair("R9 up held", 1'b1, 1'b0);
    div_p = 1'b1; tick(); div_p = 1'b0;
    chk_pair("R9 new overlap", 1'b1, 1'b1);
    tick(2);
    chk_pair("R9 new clear", 1'b0, 1'b0);
  endtask

  task automatic t_cp();
    logic [1:0] prev;
    do_reset(4'd1);
    prev = cp_code;
    for (int v = 1; v < 5; v++) begin
      cp = 2'(v);
      #1;
      chk(cp_code == prev, "R8 no early change", int'(cp_code), int'(prev));
      tick();
      chk(cp_code == 2'(v), "R8 passthrough", int'(cp_code), v);
      prev = cp_code;
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick();
    t_aligned(4'd3);
    t_aligned(4'd1);
    t_aligned(4'd0);
    t_aligned(4'd15);
    t_lead(3, 4'd2, 1'b1);
    t_lead(5, 4'd4, 1'b1);
    t_lead(2, 4'd3, 1'b0);
    t_freq();
    t_level();
    t_collide();
    t_cp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule